// File: doc/BRIEF.md
# Linked scan stream composer

This block assembles the serial load data for twelve parallel scan chains while the test runs. Nothing is precomputed as one contiguous load image. A link table holds entries. Each entry names a segment of stored pattern words, a number of extra repeats, a chain-enable mask, a fill bit and a last-entry flag. The block walks the table from a chosen index and fetches the named words from a pattern memory. It emits one word per shift cycle, one bit for each chain, and raises a shift enable that is common to all chains.

Reordering or relinking patterns only means rewriting table entries. A segment that must be applied several times, for example for initialization, is stored once and repeated by the table. Chains that are masked off carry the entry's fill bit, which supplies the padding for cores sharing a chain that are not under test. These chains are still clocked, so all chains stay aligned. A run-level mask is captured at each start. The same table sequence can therefore be replayed on a different subset of chains with no reset in between.

Both memories sit outside the block. Each has a registered read port with one cycle of latency. The walker prefetches the next table entry while the current one is shifting, so there are no idle shift cycles between entries or between repeats.

Top module: `scan_link_composer`

## Requirements
- R1: While reset is held and in the cycle after its release, shiftEn, scanOut, donePulse, tblRdEn and patRdEn are all low.
- R2: In the cycle where startPulse is high and no run is active, tblRdEn is high and tblAddr equals startIdx. The first shift cycle (shiftEn high) comes four clock cycles after that cycle.
- R3: A table word is packed, MSB first, as last flag (1 bit), fill bit (1), chain mask (12), extra repeats (4), segment length (8), start address (10). Each pass over an entry shifts the pattern words at addresses start through start+length-1, in rising order. Bit c of each word goes to chain c. Entries are taken at rising table indices from startIdx, up to and including the first entry whose last flag is set.
- R4: An entry's segment is applied (extra repeats + 1) times back to back before the next entry starts.
- R5: A chain whose bit is zero in the AND of the entry mask and the run mask outputs the entry's fill bit on every shift cycle of that entry, while shiftEn stays high for all chains.
- R6: runMask is captured at start. A second start at the same index with a different runMask replays the same stream on the chains still enabled, with no reset in between.
- R7: From the first shift cycle to the last of a run, shiftEn stays high on every cycle, across entry and repeat boundaries (each segment length is at least 2).
- R8: donePulse is high for exactly one cycle: the cycle right after the last shift cycle of the run.
- R9: A startPulse that arrives while a run is active is ignored. The stream and the single done pulse of the active run are unchanged.
- R10: Whenever shiftEn is low, scanOut is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin a run (ignored while a run is active) |
| startIdx | input | 6 | Table index of the first entry |
| runMask | input | 12 | Run-level chain enable, captured at start |
| tblRdEn | output | 1 | Link table read strobe |
| tblAddr | output | 6 | Link table read index |
| tblData | input | 36 | Table word, valid the cycle after the read |
| patRdEn | output | 1 | Pattern memory read strobe |
| patAddr | output | 10 | Pattern word address |
| patData | input | 12 | Pattern word, valid the cycle after the read |
| shiftEn | output | 1 | Shift clock enable, common to all chains |
| scanOut | output | 12 | Scan data, one bit per chain |
| donePulse | output | 1 | One-cycle end-of-run pulse |

## Verification
The hardest case to reach is a chain of short entries, each of length two with no repeats. Here the next-entry prefetch has only one cycle of margin, and a late table word would show up as a bubble in shiftEn or a wrong word at the seam. The random runs draw segment lengths from two upward and mix such entries with longer ones. The bench rebuilds every expected word from its own copies of both memories and checks that shiftEn is continuous. Directed runs cover fully masked entries, a replay under a second run mask, and a start pulse injected in the middle of a run.

// File: rtl/slc_pkg.sv
package slc_pkg;
  parameter int NUM_CHAINS = 12;
  parameter int PAT_AW     = 10;
  parameter int TBL_AW     = 6;
  parameter int LEN_W      = 8;
  parameter int REP_W      = 4;
  localparam int ENTRY_W   = 2 + NUM_CHAINS + REP_W + LEN_W + PAT_AW;

  typedef struct packed {
    logic                  lastFlag;
    logic                  fillBit;
    logic [NUM_CHAINS-1:0] chainMask;
    logic [REP_W-1:0]      extraReps;
    logic [LEN_W-1:0]      segLen;
    logic [PAT_AW-1:0]     startAddr;
  } linkEntry_t;

  typedef struct packed {
    logic                  issue;
    logic                  finalBit;
    logic [NUM_CHAINS-1:0] enMask;
    logic                  fillBit;
  } ctlStrobe_t;
endpackage

// File: rtl/slc_ctrl.sv
module slc_ctrl
  import slc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startPulse,
  input  logic [TBL_AW-1:0]     startIdx,
  input  logic [NUM_CHAINS-1:0] runMask,
  output logic                  tblRdEn,
  output logic [TBL_AW-1:0]     tblAddr,
  input  linkEntry_t            tblEntry,
  output logic                  patRdEn,
  output logic [PAT_AW-1:0]     patAddr,
  output ctlStrobe_t            strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_RUN} walkState_t;

  walkState_t            state;
  linkEntry_t            curEntry;
  linkEntry_t            nextEntry;
  logic [TBL_AW-1:0]     nextIdx;
  logic [LEN_W-1:0]      bitCnt;
  logic [REP_W-1:0]      repCnt;
  logic                  tblPend;
  logic [NUM_CHAINS-1:0] runMaskQ;

  logic endBit, endRep, endEntry, finalBit, switching, firstFetch;

  always_comb begin
    endBit     = (bitCnt == curEntry.segLen - LEN_W'(1));
    endRep     = (repCnt == curEntry.extraReps);
    endEntry   = (state == ST_RUN) && endBit && endRep;
    finalBit   = endEntry && curEntry.lastFlag;
    switching  = endEntry && !curEntry.lastFlag;
    firstFetch = (state == ST_FIRST) && !tblEntry.lastFlag;
  end

  always_comb begin
    tblRdEn = ((state == ST_IDLE) && startPulse) || firstFetch ||
              (switching && !nextEntry.lastFlag);
    tblAddr = (state == ST_IDLE) ? startIdx : nextIdx;
    patRdEn = (state == ST_RUN);
    patAddr = curEntry.startAddr + PAT_AW'(bitCnt);
    strobe.issue    = (state == ST_RUN);
    strobe.finalBit = finalBit;
    strobe.enMask   = curEntry.chainMask & runMaskQ;
    strobe.fillBit  = curEntry.fillBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      curEntry  <= '0;
      nextEntry <= '0;
      nextIdx   <= '0;
      bitCnt    <= '0;
      repCnt    <= '0;
      tblPend   <= 1'b0;
      runMaskQ  <= '0;
    end else begin
      tblPend <= firstFetch || (switching && !nextEntry.lastFlag);
      if (tblPend) nextEntry <= tblEntry;
      case (state)
        ST_IDLE: begin
          if (startPulse) begin
            state    <= ST_FIRST;
            nextIdx  <= startIdx + TBL_AW'(1);
            runMaskQ <= runMask;
          end
        end
        ST_FIRST: begin
          curEntry <= tblEntry;
          bitCnt   <= '0;
          repCnt   <= '0;
          if (!tblEntry.lastFlag) nextIdx <= nextIdx + TBL_AW'(1);
          state <= ST_RUN;
        end
        ST_RUN: begin
          if (!endBit) begin
            bitCnt <= bitCnt + LEN_W'(1);
          end else begin
            bitCnt <= '0;
            if (!endRep) begin
              repCnt <= repCnt + REP_W'(1);
            end else begin
              repCnt <= '0;
              if (curEntry.lastFlag) begin
                state <= ST_IDLE;
              end else begin
                curEntry <= nextEntry;
                if (!nextEntry.lastFlag) nextIdx <= nextIdx + TBL_AW'(1);
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slc_dpath.sv
module slc_dpath
  import slc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobe_t            strobe,
  input  logic [NUM_CHAINS-1:0] patData,
  output logic                  shiftEn,
  output logic [NUM_CHAINS-1:0] scanOut,
  output logic                  donePulse
);
  logic                  validQ;
  logic                  finalQ;
  logic [NUM_CHAINS-1:0] maskQ;
  logic                  fillQ;
  logic                  finalOutQ;
  logic [NUM_CHAINS-1:0] composed;

  always_comb begin
    composed = (patData & maskQ) | ({NUM_CHAINS{fillQ}} & ~maskQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ    <= 1'b0;
      finalQ    <= 1'b0;
      maskQ     <= '0;
      fillQ     <= 1'b0;
      shiftEn   <= 1'b0;
      scanOut   <= '0;
      finalOutQ <= 1'b0;
      donePulse <= 1'b0;
    end else begin
      validQ    <= strobe.issue;
      finalQ    <= strobe.issue && strobe.finalBit;
      maskQ     <= strobe.enMask;
      fillQ     <= strobe.fillBit;
      shiftEn   <= validQ;
      scanOut   <= validQ ? composed : '0;
      finalOutQ <= validQ && finalQ;
      donePulse <= finalOutQ;
    end
  end
endmodule

// File: rtl/scan_link_composer.sv
module scan_link_composer
  import slc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startPulse,
  input  logic [TBL_AW-1:0]     startIdx,
  input  logic [NUM_CHAINS-1:0] runMask,
  output logic                  tblRdEn,
  output logic [TBL_AW-1:0]     tblAddr,
  input  logic [ENTRY_W-1:0]    tblData,
  output logic                  patRdEn,
  output logic [PAT_AW-1:0]     patAddr,
  input  logic [NUM_CHAINS-1:0] patData,
  output logic                  shiftEn,
  output logic [NUM_CHAINS-1:0] scanOut,
  output logic                  donePulse
);
  ctlStrobe_t strobe;
  linkEntry_t tblEntry;

  assign tblEntry = linkEntry_t'(tblData);

  slc_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startIdx(startIdx),
    .runMask(runMask), .tblRdEn(tblRdEn), .tblAddr(tblAddr),
    .tblEntry(tblEntry), .patRdEn(patRdEn), .patAddr(patAddr),
    .strobe(strobe)
  );

  slc_dpath i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .patData(patData),
    .shiftEn(shiftEn), .scanOut(scanOut), .donePulse(donePulse)
  );
endmodule

// File: rtl/scan_link_composer_chk.sv
module scan_link_composer_chk
  import slc_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  patRdEn,
  input logic                  shiftEn,
  input logic [NUM_CHAINS-1:0] scanOut,
  input logic                  donePulse
);
  AST_READ_GIVES_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    $past(patRdEn, 2) |-> shiftEn); // R3
  AST_SHIFT_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    shiftEn |-> $past(patRdEn, 2)); // R7
  AST_DONE_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> ($past(shiftEn) && !shiftEn)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !shiftEn |-> (scanOut == '0)); // R10
endmodule

bind scan_link_composer scan_link_composer_chk i_chk (
  .clk(clk), .rstN(rstN), .patRdEn(patRdEn), .shiftEn(shiftEn),
  .scanOut(scanOut), .donePulse(donePulse)
);

// File: tb/test_scan_link_composer.sv
module test_scan_link_composer;
  import slc_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic [TBL_AW-1:0] startIdx = '0;
  logic [NUM_CHAINS-1:0] runMask = '0;
  logic tblRdEn, patRdEn, shiftEn, donePulse;
  logic [TBL_AW-1:0] tblAddr;
  logic [PAT_AW-1:0] patAddr;
  logic [ENTRY_W-1:0] tblData = '0;
  logic [NUM_CHAINS-1:0] patData = '0;
  logic [NUM_CHAINS-1:0] scanOut;

  logic [ENTRY_W-1:0] tblMem [0:(1<<TBL_AW)-1];
  logic [NUM_CHAINS-1:0] patMem [0:(1<<PAT_AW)-1];
  logic [NUM_CHAINS-1:0] expWords [0:2047];
  int expCount;
  int checkCnt = 0;
  int failCnt = 0;
  int seedDummy;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (tblRdEn) tblData <= tblMem[tblAddr];
    if (patRdEn) patData <= patMem[patAddr];
  end

  scan_link_composer i_scan_link_composer (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startIdx(startIdx),
    .runMask(runMask), .tblRdEn(tblRdEn), .tblAddr(tblAddr), .tblData(tblData),
    .patRdEn(patRdEn), .patAddr(patAddr), .patData(patData),
    .shiftEn(shiftEn), .scanOut(scanOut), .donePulse(donePulse)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [ENTRY_W-1:0] mkEntry(input bit lastF, input bit fill,
      input logic [NUM_CHAINS-1:0] mask, input int reps, input int len, input int start);
    return {lastF, fill, mask, REP_W'(reps), LEN_W'(len), PAT_AW'(start)};
  endfunction

  task automatic buildExpected(input int sIdx, input logic [NUM_CHAINS-1:0] rMask);
    int idx = sIdx;
    linkEntry_t e;
    expCount = 0;
    for (int guard = 0; guard < 64; guard++) begin
      e = linkEntry_t'(tblMem[idx[TBL_AW-1:0]]);
      for (int r = 0; r <= int'(e.extraReps); r++) begin
        for (int b = 0; b < int'(e.segLen); b++) begin
          logic [NUM_CHAINS-1:0] en = e.chainMask & rMask;
          logic [NUM_CHAINS-1:0] w = patMem[(int'(e.startAddr) + b) % (1<<PAT_AW)];
          expWords[expCount] = (w & en) | ({NUM_CHAINS{e.fillBit}} & ~en);
          expCount++;
        end
      end
      if (e.lastFlag) break;
      idx++;
    end
  endtask

  task automatic runSeq(input int sIdx, input logic [NUM_CHAINS-1:0] rMask,
                        input string dataTag, input bit poke);
    buildExpected(sIdx, rMask);
    @(negedge clk);
    startPulse = 1'b1;
    startIdx = TBL_AW'(sIdx);
    runMask = rMask;
    #1;
    chk(tblRdEn && (tblAddr == TBL_AW'(sIdx)), "R2 table read at start", {tblRdEn, tblAddr}, {1'b1, TBL_AW'(sIdx)});
    for (int j = 1; j <= expCount + 5; j++) begin
      @(negedge clk);
      if (j == 1) begin
        startPulse = 1'b0;
        runMask = ~rMask;
      end
      if (poke && j == 6) begin
        startPulse = 1'b1;
        startIdx = TBL_AW'(sIdx + 1);
      end
      if (poke && j == 7) startPulse = 1'b0;
      if (j < 4) begin
        chk(!shiftEn && !donePulse, "R2 no shift before latency", {shiftEn, donePulse}, 0);
        chk(scanOut == '0, "R10 idle data zero", scanOut, 0);
      end else if (j < 4 + expCount) begin
        chk(shiftEn, "R7 shift continuous", shiftEn, 1);
        chk(scanOut == expWords[j-4], dataTag, scanOut, expWords[j-4]);
        chk(!donePulse, "R8 no early done", donePulse, 0);
      end else if (j == 4 + expCount) begin
        chk(!shiftEn && donePulse, "R8 done after last shift", {shiftEn, donePulse}, 1);
        chk(scanOut == '0, "R10 idle data zero", scanOut, 0);
      end else begin
        chk(!shiftEn && !donePulse, poke ? "R9 late start ignored" : "R8 done single",
            {shiftEn, donePulse}, 0);
      end
    end
  endtask

  task automatic randomChain(input int sIdx, input int nEnt);
    for (int k = 0; k < nEnt; k++) begin
      int len = 2 + ($urandom % 19);
      int start = $urandom % (1024 - 32);
      tblMem[sIdx + k] = mkEntry(k == nEnt - 1, 1'($urandom), NUM_CHAINS'($urandom),
                                 $urandom % 4, len, start);
    end
  endtask

  initial begin
    #(4 * 150000);
    failCnt++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    seedDummy = $urandom(32'h5EED1234);
    for (int a = 0; a < (1<<PAT_AW); a++) patMem[a] = NUM_CHAINS'($urandom);
    for (int t = 0; t < (1<<TBL_AW); t++) tblMem[t] = mkEntry(1, 0, '1, 0, 2, 0);

    repeat (4) @(negedge clk);
    chk(!shiftEn && !donePulse && !tblRdEn && !patRdEn && scanOut == '0, "R1 outputs in reset",
        {shiftEn, donePulse, tblRdEn, patRdEn, scanOut}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!shiftEn && !donePulse && !tblRdEn && !patRdEn && scanOut == '0, "R1 outputs after reset",
        {shiftEn, donePulse, tblRdEn, patRdEn, scanOut}, 0);

    tblMem[0] = mkEntry(1, 0, '1, 0, 5, 100);
    runSeq(0, '1, "R3 single segment data", 0);

    tblMem[1] = mkEntry(1, 0, '1, 3, 4, 200);
    runSeq(1, '1, "R4 repeated segment data", 0);

    tblMem[10] = mkEntry(0, 0, 12'hFFF, 1, 2, 300);
    tblMem[11] = mkEntry(0, 1, 12'h0F0, 0, 2, 310);
    tblMem[12] = mkEntry(0, 0, 12'hA5A, 2, 3, 320);
    tblMem[13] = mkEntry(1, 1, 12'h00F, 0, 2, 330);
    runSeq(10, 12'hFFF, "R3 linked entries data", 0);
    runSeq(10, 12'h3C3, "R6 replay with new run mask", 0);

    tblMem[20] = mkEntry(0, 1, 12'h000, 0, 6, 400);
    tblMem[21] = mkEntry(1, 0, 12'h000, 1, 3, 410);
    runSeq(20, '1, "R5 masked chains carry fill", 0);

    tblMem[30] = mkEntry(0, 0, '1, 1, 8, 500);
    tblMem[31] = mkEntry(1, 0, '1, 0, 8, 520);
    runSeq(30, '1, "R9 stream under late start", 1);

    for (int it = 0; it < 40; it++) begin
      int sIdx = 40 + ($urandom % 20);
      int nEnt = 1 + ($urandom % 4);
      randomChain(sIdx, nEnt);
      runSeq(sIdx, (it % 3 == 0) ? NUM_CHAINS'($urandom) : '1, "R3 random stream data", 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule